// File: doc/BRIEF.md
# Edge-Positioned Multi-Channel PWM Generator

This block drives up to sixteen pulse-width outputs from one shared time base. A prescale counter divides the input clock, and a step counter advances once per prescale wrap, so every output repeats every (prescale+1)·(period+1) clock cycles. No channel holds a duty-cycle value. Each channel holds two step positions instead: at one the output is driven high, at the other it is driven low. Inverted polarity comes from placing the low position before the high one. A position beyond the period is never reached, which lets software hold a channel at a steady level.

Software reaches the block over a small byte-addressed register bus with word-aligned registers. Writes take effect on a clock edge and reads are combinational. At build time a mask parameter picks the channels that carry shadow copies of their edge registers. For those channels, when the global synchronous-update bit is set, edge writes wait in the shadow copies and are committed when the step counter wraps. The period in progress therefore completes unchanged. Reads always return the edge values that are active at the time.

Top module: `pwm_edge_gen`

## Requirements
- R1: After reset every register reads 0, both counters are at 0 and every output is low.
- R2: Register addresses are byte offsets on word boundaries. 0x00 holds the prescale value, 0x04 the period value and 0xE4 the synchronous-update bit in bit 0. 0x08 holds the enables of channels 0-7 (bit i for channel i) and 0x0C those of channels 8-15 (bit i-8). 0x10+8i holds the high-edge position of channel i and 0x14+8i its low-edge position. A register is written on the clock edge on which bus_we is high, and bus_rdata shows the register at bus_addr combinationally.
- R3: The prescale counter counts from 0 up to the prescale value and then returns to 0. The step counter advances on each prescale wrap, counts from 0 up to the period value and then returns to 0. Every output repeats every (prescale+1)·(period+1) cycles.
- R4: An enabled channel's output goes high on the clock after the step counter first takes the high-edge value, and goes low on the clock after it first takes the low-edge value. The output holds its level in between, so it is high for ((low−high) mod (period+1))·(prescale+1) cycles.
- R5: A low-edge value below the high-edge value gives the inverted waveform, which is high across the period boundary.
- R6: Equal high-edge and low-edge values toggle the output once per period at that step. This gives a 50% waveform with twice the programmed period.
- R7: An edge value greater than the period value never fires, so the output stays at the level set by the other edge.
- R8: A channel whose enable bit is 0 drives its output low, starting one clock after the enable bit clears.
- R9: Edge writes to a channel without shadow registers take effect and read back at once, whatever the synchronous-update bit holds.
- R10: For a shadowed channel with the synchronous-update bit at 1, an edge write leaves the active value and its read-back unchanged until the next step-counter wrap, which loads the written value.
- R11: For a shadowed channel with the synchronous-update bit at 0, edge writes take effect at once.
- R12: Channels at or above NUM_CH read 0 in their edge registers and in their enable bits, and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pwm_out | output | NUM_CH | Channel outputs |

## Verification
The hardest case to reach is a deferred edge write on a shadowed channel. The ports show neither the counter phase nor the moment of a wrap. The bench sets the synchronous-update bit and rewrites the low edge of a shadowed channel. It reads the old value back at once, waits longer than two full periods so that a wrap must have occurred, then reads the new value and measures the shortened high time. Waveform checks also avoid depending on phase: each measurement waits for a fresh rising edge and counts the high and total cycles from there.

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
  parameter int          NUM_CH      = 16,
  parameter logic [15:0] SHADOW_MASK = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam logic [15:0] CH_MASK =
    (NUM_CH >= 16) ? 16'hFFFF : 16'((32'd1 << NUM_CH) - 32'd1);

  logic [7:0]  presc_q, period_q, pre_cnt, step_cnt;
  logic        sync_q;
  logic [15:0] en_q;
  logic [15:0][7:0] rise_v, fall_v;
  logic [NUM_CH-1:0] out_v;

  wire tick     = pre_cnt >= presc_q;
  wire wrap     = tick && (step_cnt >= period_q);
  wire first    = pre_cnt == 8'd0;
  wire edge_hit = (bus_addr[1:0] == 2'b00) && (bus_addr >= 8'h10) && (bus_addr < 8'h90);
  wire [3:0] ech   = bus_addr[6:3] - 4'd2;
  wire       efall = bus_addr[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      step_cnt <= '0;
    end else begin
      pre_cnt <= tick ? 8'd0 : pre_cnt + 8'd1;
      if (tick) step_cnt <= wrap ? 8'd0 : step_cnt + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q  <= '0;
      period_q <= '0;
      sync_q   <= 1'b0;
      en_q     <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        8'h00: presc_q     <= bus_wdata;
        8'h04: period_q    <= bus_wdata;
        8'h08: en_q[7:0]   <= bus_wdata & CH_MASK[7:0];
        8'h0C: en_q[15:8]  <= bus_wdata & CH_MASK[15:8];
        8'hE4: sync_q      <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < 16; c++) begin : g_ch
    if (c < NUM_CH) begin : g_on
      localparam bit SHADOW = SHADOW_MASK[c];
      logic [7:0] rise_sh, fall_sh, rise_act, fall_act;
      logic       o_q;
      wire sel   = bus_we && edge_hit && (ech == 4'(c));
      wire wr_r  = sel && !efall;
      wire wr_f  = sel && efall;
      wire defer = SHADOW && sync_q;
      wire hit_r = first && (step_cnt == rise_act);
      wire hit_f = first && (step_cnt == fall_act);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rise_sh  <= '0;
          fall_sh  <= '0;
          rise_act <= '0;
          fall_act <= '0;
        end else begin
          if (wr_r) rise_sh <= bus_wdata;
          if (wr_f) fall_sh <= bus_wdata;
          if (wr_r && !defer)      rise_act <= bus_wdata;
          else if (SHADOW && wrap) rise_act <= rise_sh;
          if (wr_f && !defer)      fall_act <= bus_wdata;
          else if (SHADOW && wrap) fall_act <= fall_sh;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              o_q <= 1'b0;
        else if (!en_q[c])       o_q <= 1'b0;
        else if (hit_r && hit_f) o_q <= ~o_q;
        else if (hit_r)          o_q <= 1'b1;
        else if (hit_f)          o_q <= 1'b0;
      end

      assign rise_v[c] = rise_act;
      assign fall_v[c] = fall_act;
      assign out_v[c]  = o_q;
    end else begin : g_off
      assign rise_v[c] = '0;
      assign fall_v[c] = '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      8'h00: bus_rdata = presc_q;
      8'h04: bus_rdata = period_q;
      8'h08: bus_rdata = en_q[7:0];
      8'h0C: bus_rdata = en_q[15:8];
      8'hE4: bus_rdata = {7'd0, sync_q};
      default: if (edge_hit) bus_rdata = efall ? fall_v[ech] : rise_v[ech];
    endcase
  end

  assign pwm_out = out_v;
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk #(
  parameter int          NUM_CH      = 16,
  parameter logic [15:0] SHADOW_MASK = 16'hFF00
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [7:0]             pre_cnt,
  input logic [7:0]             presc_q,
  input logic [7:0]             step_cnt,
  input logic                   sync_q,
  input logic                   wrap,
  input logic [NUM_CH-1:0]      en_q,
  input logic [NUM_CH-1:0][7:0] rise_v,
  input logic [NUM_CH-1:0][7:0] fall_v,
  input logic [NUM_CH-1:0]      out_v
);
  assert_presc_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt < presc_q) |=> (pre_cnt == $past(pre_cnt) + 8'd1));

  assert_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt < presc_q) |=> $stable(step_cnt));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_dis_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[c] |=> !out_v[c]);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[c] && pre_cnt != 8'd0) |=> $stable(out_v[c]));

    if (SHADOW_MASK[c]) begin : g_sh
      assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q && !wrap) |=> ($stable(rise_v[c]) && $stable(fall_v[c])));
    end
  end
endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(.NUM_CH(NUM_CH), .SHADOW_MASK(SHADOW_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .pre_cnt(pre_cnt), .presc_q(presc_q),
  .step_cnt(step_cnt), .sync_q(sync_q), .wrap(wrap),
  .en_q(en_q[NUM_CH-1:0]), .rise_v(rise_v[NUM_CH-1:0]),
  .fall_v(fall_v[NUM_CH-1:0]), .out_v(out_v)
);

// File: tb/pwm_edge_gen_tb_top.sv
module pwm_edge_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int n_chk = 0, n_fail = 0, cyc = 0;

  pwm_edge_gen #(.NUM_CH(NCH), .SHADOW_MASK(16'h0F00)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, cycles=%0d expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic measure(input int ch, output int hi, output int per);
    int t = 0;
    @(negedge clk);
    while (pwm_out[ch] !== 1'b0 && t < 600) begin @(negedge clk); t++; end
    while (pwm_out[ch] !== 1'b1 && t < 600) begin @(negedge clk); t++; end
    hi = 0;
    while (pwm_out[ch] === 1'b1 && t < 600) begin @(negedge clk); hi++; t++; end
    per = hi;
    while (pwm_out[ch] === 1'b0 && t < 600) begin @(negedge clk); per++; t++; end
  endtask

  task automatic t_reset;
    chk(pwm_out == '0, "R1 outputs low", int'(pwm_out), 0);
    rd_chk(8'h00, 8'h00, "R1 prescale");
    rd_chk(8'h04, 8'h00, "R1 period");
    rd_chk(8'h08, 8'h00, "R1 enable lo");
    rd_chk(8'h0C, 8'h00, "R1 enable hi");
    rd_chk(8'h10, 8'h00, "R1 ch0 rise");
    rd_chk(8'hE4, 8'h00, "R1 sync");
  endtask

  task automatic t_unimpl;
    wr(8'h0C, 8'hFF);
    rd_chk(8'h0C, 8'h0F, "R12 enable bits above NUM_CH");
    wr(8'h70, 8'h05);
    rd_chk(8'h70, 8'h00, "R12 ch12 rise ignored");
    wr(8'h8C, 8'h07);
    rd_chk(8'h8C, 8'h00, "R12 ch15 fall ignored");
  endtask

  task automatic t_regs;
    wr(8'h00, 8'd1);
    wr(8'h04, 8'd9);
    rd_chk(8'h00, 8'd1, "R2 prescale readback");
    rd_chk(8'h04, 8'd9, "R2 period readback");
    wr(8'h10, 8'd2); wr(8'h14, 8'd7);
    wr(8'h18, 8'd7); wr(8'h1C, 8'd3);
    wr(8'h20, 8'd4); wr(8'h24, 8'd4);
    wr(8'h28, 8'd0); wr(8'h2C, 8'd200);
    wr(8'h30, 8'd200); wr(8'h34, 8'd0);
    rd_chk(8'h2C, 8'd200, "R2 ch3 fall readback");
    wr(8'h08, 8'h1F);
    rd_chk(8'h08, 8'h1F, "R2 enable readback");
  endtask

  task automatic t_basic;
    int hi, per;
    measure(0, hi, per);
    chk(hi == 10, "R4 ch0 high cycles", hi, 10);
    chk(per == 20, "R3 ch0 period cycles", per, 20);
  endtask

  task automatic t_invert;
    int hi, per;
    measure(1, hi, per);
    chk(hi == 12, "R5 inverted high cycles", hi, 12);
    chk(per == 20, "R5 inverted period", per, 20);
  endtask

  task automatic t_equal;
    int hi, per;
    measure(2, hi, per);
    chk(hi == 20, "R6 toggle high cycles", hi, 20);
    chk(per == 40, "R6 toggle period", per, 40);
  endtask

  task automatic t_beyond;
    int bad3 = 0, bad4 = 0;
    repeat (45) @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pwm_out[3] !== 1'b1) bad3++;
      if (pwm_out[4] !== 1'b0) bad4++;
    end
    chk(bad3 == 0, "R7 unreachable low edge keeps high", bad3, 0);
    chk(bad4 == 0, "R7 unreachable high edge keeps low", bad4, 0);
  endtask

  task automatic t_shadow;
    int hi, per;
    wr(8'h50, 8'd1); wr(8'h54, 8'd5);
    rd_chk(8'h54, 8'd5, "R11 shadowed immediate with sync off");
    measure(8, hi, per);
    chk(hi == 8, "R11 ch8 high cycles", hi, 8);
    wr(8'hE4, 8'h01);
    rd_chk(8'hE4, 8'h01, "R2 sync readback");
    wr(8'h54, 8'd3);
    rd_chk(8'h54, 8'd5, "R10 deferred read shows active");
    wr(8'h14, 8'd6);
    rd_chk(8'h14, 8'd6, "R9 unshadowed immediate with sync on");
    repeat (45) @(negedge clk);
    rd_chk(8'h54, 8'd3, "R10 committed after wrap");
    measure(8, hi, per);
    chk(hi == 4, "R10 ch8 new high cycles", hi, 4);
    chk(per == 20, "R10 ch8 period", per, 20);
  endtask

  task automatic t_disable;
    int t = 0;
    @(negedge clk);
    while (pwm_out[0] !== 1'b1 && t < 100) begin @(negedge clk); t++; end
    wr(8'h08, 8'h1E);
    @(posedge clk);
    #1 chk(pwm_out[0] == 1'b0, "R8 disabled output low", int'(pwm_out[0]), 0);
    repeat (30) @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R8 stays low", int'(pwm_out[0]), 0);
  endtask

  task automatic t_fast;
    int hi, per;
    wr(8'h00, 8'd0);
    wr(8'h04, 8'd4);
    wr(8'h10, 8'd1); wr(8'h14, 8'd3);
    wr(8'h08, 8'h1F);
    measure(0, hi, per);
    chk(hi == 2, "R4 fast high cycles", hi, 2);
    chk(per == 5, "R3 fast period cycles", per, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unimpl();
    t_regs();
    t_basic();
    t_invert();
    t_equal();
    t_beyond();
    t_shadow();
    t_disable();
    t_fast();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule